// File: doc/BRIEF.md
# Test instruction register with opcode decoder

This block holds the current test instruction of a boundary-scan port and turns it into the select and control lines used by the rest of the test logic. An external TAP controller supplies the test clock, serial data in and one strobe per controller state of interest: capture, shift, update and test-logic-reset. The block answers with a serial bit toward the test data output, the held 3-bit instruction and six decoded lines.

The register has two ranks. A 3-bit shift stage loads a fixed pattern on capture and then moves one place toward the serial output on each shift clock. A parallel hold stage copies the shift stage only on update, so the instruction in force stays fixed while a new one is being scanned in. Both ranks come out of reset holding the all-ones code, which selects the bypass path.

Five instructions are decoded. Two select the boundary register: external test, which also drives the pins from the boundary cells and asks the system logic to stay in reset, and preload. The other three select the 1-bit bypass path: plain bypass, output high impedance, and clamp, which keeps the pins driven from the held boundary cells.

Top module: `tst_ir_ctrl`

## Requirements
- R1: While rst_ni is low, ir_o reads 3'b111 (bit2 bit1 bit0) at once, without a clock edge, and the shift stage is also set to 3'b111.
- R2: A rising tck_i edge with tlr_i high sets ir_o and the shift stage to 3'b111, taking priority over every other strobe.
- R3: A rising tck_i edge with capture_i high loads the shift stage with 3'b101; on the next falling edge tdo_o shows its bit0, which is 1.
- R4: On each rising tck_i edge with shift_i high the shift stage moves one place toward bit0 with tdi_i entering bit2; tdo_o takes the new bit0 on the following falling edge, so after a capture tdo_o reads 1, 0, 1 and then the shifted-in bits.
- R5: ir_o and all decoded outputs keep their value on every edge without update_i or tlr_i, including through capture and shift.
- R6: A rising tck_i edge with update_i high copies the shift stage into ir_o.
- R7: ir_o = 3'b000 (external test) raises bsr_sel_o, cell_drive_o and sys_rst_req_o; byp_sel_o, hiz_o and clamp_o are low.
- R8: ir_o = 3'b001 (preload) raises bsr_sel_o only.
- R9: Any ir_o with bit1 set (3'b010, 3'b011, 3'b110, 3'b111) raises byp_sel_o only.
- R10: ir_o = 3'b100 raises byp_sel_o and hiz_o only.
- R11: ir_o = 3'b101 raises byp_sel_o, clamp_o and cell_drive_o; sys_rst_req_o and hiz_o are low.
- R12: Exactly one of bsr_sel_o and byp_sel_o is high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tlr_i | input | 1 | Controller is in test-logic-reset (synchronous) |
| capture_i | input | 1 | Controller is in the instruction capture state |
| shift_i | input | 1 | Controller is in the instruction shift state |
| update_i | input | 1 | Controller is in the instruction update state |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial instruction bit toward the test data output, falling-edge timed |
| ir_o | output | 3 | Instruction in force |
| bsr_sel_o | output | 1 | Boundary register is the selected data register |
| byp_sel_o | output | 1 | Bypass flop is the selected data register |
| cell_drive_o | output | 1 | Device pins take their values from the boundary output cells |
| hiz_o | output | 1 | All device output drivers off |
| clamp_o | output | 1 | Pins held from the boundary cells while bypass is selected |
| sys_rst_req_o | output | 1 | Request to hold the system logic in reset |

## Verification
The assertions take for granted that the controller raises at most one of tlr_i, capture_i, shift_i and update_i in any cycle, since it can only be in one state; the hold and load properties are written on that basis. The stimulus tasks raise a single strobe at a time, change inputs just after the rising edge and return every strobe to low before the next task starts. Asynchronous reset is applied and released well away from any clock edge, so no property is asked to judge a cycle in which reset changes.

// File: rtl/tst_ir_pkg.sv
package tst_ir_pkg;
  localparam int unsigned IR_W = 3;
  typedef logic [IR_W-1:0] opc_t;

  localparam opc_t OPC_EXT   = 3'b000;
  localparam opc_t OPC_PRE   = 3'b001;
  localparam opc_t OPC_HIZ   = 3'b100;
  localparam opc_t OPC_CLAMP = 3'b101;
  localparam opc_t OPC_BYP   = 3'b111;

  localparam opc_t CAPT_VAL  = OPC_CLAMP;
  localparam opc_t RST_VAL   = OPC_BYP;

  typedef struct packed {
    logic bsr_sel;
    logic byp_sel;
    logic cell_drive;
    logic hiz;
    logic clamp;
    logic sys_rst_req;
  } ctl_t;
endpackage

// File: rtl/tst_ir_shift.sv
module tst_ir_shift #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] CAPT = '0,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         tlr_i,
  input  logic         capture_i,
  input  logic         shift_i,
  input  logic         tdi_i,
  output logic [W-1:0] sr_o,
  output logic         tdo_o
);
  logic [W-1:0] sr_q;
  logic         tdo_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)        sr_q <= RST;
    else if (tlr_i)     sr_q <= RST;
    else if (capture_i) sr_q <= CAPT;
    else if (shift_i)   sr_q <= {tdi_i, sr_q[W-1:1]};
  end

  // serial out retimed to the falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b0;
    else         tdo_q <= sr_q[0];
  end

  assign sr_o  = sr_q;
  assign tdo_o = tdo_q;
endmodule

// File: rtl/tst_ir_hold.sv
module tst_ir_hold #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST = '1
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         tlr_i,
  input  logic         update_i,
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] ir_o
);
  logic [W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       ir_q <= RST;
    else if (tlr_i)    ir_q <= RST;
    else if (update_i) ir_q <= sr_i;
  end

  assign ir_o = ir_q;
endmodule

// File: rtl/tst_ir_decode.sv
module tst_ir_decode
  import tst_ir_pkg::*;
(
  input  opc_t ir_i,
  output ctl_t ctl_o
);
  always_comb begin
    ctl_o = '0;
    casez (ir_i)
      3'b?1?: ctl_o.byp_sel = 1'b1;
      OPC_EXT: begin
        ctl_o.bsr_sel     = 1'b1;
        ctl_o.cell_drive  = 1'b1;
        ctl_o.sys_rst_req = 1'b1;
      end
      OPC_PRE: ctl_o.bsr_sel = 1'b1;
      OPC_HIZ: begin
        ctl_o.byp_sel = 1'b1;
        ctl_o.hiz     = 1'b1;
      end
      OPC_CLAMP: begin
        ctl_o.byp_sel    = 1'b1;
        ctl_o.clamp      = 1'b1;
        ctl_o.cell_drive = 1'b1;
      end
      default: ctl_o.byp_sel = 1'b1;
    endcase
  end
endmodule

// File: rtl/tst_ir_ctrl.sv
module tst_ir_ctrl
  import tst_ir_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            tlr_i,
  input  logic            capture_i,
  input  logic            shift_i,
  input  logic            update_i,
  input  logic            tdi_i,
  output logic            tdo_o,
  output logic [IR_W-1:0] ir_o,
  output logic            bsr_sel_o,
  output logic            byp_sel_o,
  output logic            cell_drive_o,
  output logic            hiz_o,
  output logic            clamp_o,
  output logic            sys_rst_req_o
);
  opc_t sr_q;
  opc_t ir_q;
  ctl_t ctl;

  tst_ir_shift #(.W(IR_W), .CAPT(CAPT_VAL), .RST(RST_VAL)) u_shift (
    .tck_i     (tck_i),
    .rst_ni    (rst_ni),
    .tlr_i     (tlr_i),
    .capture_i (capture_i),
    .shift_i   (shift_i),
    .tdi_i     (tdi_i),
    .sr_o      (sr_q),
    .tdo_o     (tdo_o)
  );

  tst_ir_hold #(.W(IR_W), .RST(RST_VAL)) u_hold (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tlr_i    (tlr_i),
    .update_i (update_i),
    .sr_i     (sr_q),
    .ir_o     (ir_q)
  );

  tst_ir_decode u_dec (
    .ir_i  (ir_q),
    .ctl_o (ctl)
  );

  assign ir_o          = ir_q;
  assign bsr_sel_o     = ctl.bsr_sel;
  assign byp_sel_o     = ctl.byp_sel;
  assign cell_drive_o  = ctl.cell_drive;
  assign hiz_o         = ctl.hiz;
  assign clamp_o       = ctl.clamp;
  assign sys_rst_req_o = ctl.sys_rst_req;
endmodule

// File: rtl/tst_ir_ctrl_chk.sv
module tst_ir_ctrl_chk (
  input logic       tck_i,
  input logic       rst_ni,
  input logic       tlr_i,
  input logic       capture_i,
  input logic       shift_i,
  input logic       update_i,
  input logic       tdi_i,
  input logic [2:0] sr_i,
  input logic [2:0] ir_o,
  input logic       bsr_sel_o,
  input logic       byp_sel_o,
  input logic       cell_drive_o,
  input logic       hiz_o,
  input logic       clamp_o,
  input logic       sys_rst_req_o
);
  // controller states are exclusive (R6 relies on it)
  p_strobe_excl_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $onehot0({tlr_i, capture_i, shift_i, update_i}));

  p_tlr_force_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (ir_o == 3'b111 && sr_i == 3'b111));

  p_capture_load_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (capture_i && !tlr_i) |=> sr_i == 3'b101);

  p_shift_entry_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !tlr_i && !capture_i) |=> (sr_i[2] == $past(tdi_i) && sr_i[1:0] == $past(sr_i[2:1])));

  p_ir_hold_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (!update_i && !tlr_i) |=> $stable(ir_o));

  p_update_load_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_i && !tlr_i) |=> ir_o == $past(sr_i));

  p_ext_rst_r7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    sys_rst_req_o |-> (bsr_sel_o && cell_drive_o && !clamp_o));

  p_hiz_byp_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hiz_o |-> (byp_sel_o && !cell_drive_o && ir_o == 3'b100));

  p_clamp_byp_r11: assert property (@(posedge tck_i) disable iff (!rst_ni)
    clamp_o |-> (byp_sel_o && cell_drive_o && !sys_rst_req_o && !hiz_o));

  p_sel_excl_r12: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $countones({bsr_sel_o, byp_sel_o}) == 1);
endmodule

bind tst_ir_ctrl tst_ir_ctrl_chk u_chk (
  .tck_i         (tck_i),
  .rst_ni        (rst_ni),
  .tlr_i         (tlr_i),
  .capture_i     (capture_i),
  .shift_i       (shift_i),
  .update_i      (update_i),
  .tdi_i         (tdi_i),
  .sr_i          (sr_q),
  .ir_o          (ir_o),
  .bsr_sel_o     (bsr_sel_o),
  .byp_sel_o     (byp_sel_o),
  .cell_drive_o  (cell_drive_o),
  .hiz_o         (hiz_o),
  .clamp_o       (clamp_o),
  .sys_rst_req_o (sys_rst_req_o)
);

// File: tb/tst_ir_ctrl_tb_top.sv
module tst_ir_ctrl_tb_top;
  logic       tck_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tlr_i = 1'b0, capture_i = 1'b0, shift_i = 1'b0, update_i = 1'b0, tdi_i = 1'b0;
  logic       tdo_o;
  logic [2:0] ir_o;
  logic       bsr_sel_o, byp_sel_o, cell_drive_o, hiz_o, clamp_o, sys_rst_req_o;
  logic [5:0] ctl_v;

  int n_chk = 0;
  int n_bad = 0;

  always #4 tck_i = ~tck_i;

  tst_ir_ctrl dut_i (.*);

  assign ctl_v = {bsr_sel_o, byp_sel_o, cell_drive_o, hiz_o, clamp_o, sys_rst_req_o};

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck_i);
    #1;
  endtask

  // {bsr, byp, cell, hiz, clamp, sysrst}
  function automatic logic [5:0] exp_ctl(input logic [2:0] c);
    if (c[1])            return 6'b010000;
    else if (c == 3'b000) return 6'b101001;
    else if (c == 3'b001) return 6'b100000;
    else if (c == 3'b100) return 6'b010100;
    else                 return 6'b011010;
  endfunction

  function automatic string dec_tag(input logic [2:0] c);
    if (c[1])             return "R9 bypass";
    else if (c == 3'b000) return "R7 extest";
    else if (c == 3'b001) return "R8 preload";
    else if (c == 3'b100) return "R10 hiz";
    else                  return "R11 clamp";
  endfunction

  task automatic load_ir(input logic [2:0] c);
    capture_i = 1'b1;
    tick();
    capture_i = 1'b0;
    shift_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tdi_i = c[i];
      tick();
    end
    shift_i = 1'b0;
    tdi_i = 1'b0;
    update_i = 1'b1;
    tick();
    update_i = 1'b0;
  endtask

  task automatic t_reset();
    #10;
    check("R1 ir in reset", 8'(ir_o), 8'h7);
    check("R9 ctl in reset", 8'(ctl_v), 8'(6'b010000));
    @(negedge tck_i);
    rst_ni = 1'b1;
    tick();
    check("R1 ir after release", 8'(ir_o), 8'h7);
  endtask

  task automatic t_capture_shift();
    logic [3:0] exp_bits = 4'b0101; // read from bit0 upward: 1,0,1,0
    capture_i = 1'b1;
    tick();
    capture_i = 1'b0;
    shift_i = 1'b1;
    tdi_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge tck_i);
      #1;
      check(i == 0 ? "R3 captured bit0" : "R4 shifted bit", 8'(tdo_o), 8'(exp_bits[i]));
      check("R5 ir held during shift", 8'(ir_o), 8'h7);
      @(posedge tck_i);
      #1;
    end
    shift_i = 1'b0;
    tick();
    check("R5 ir held without update", 8'(ir_o), 8'h7);
  endtask

  task automatic t_decode_all();
    for (int c = 0; c < 8; c++) begin
      load_ir(3'(c));
      check("R6 ir after update", 8'(ir_o), 8'(c));
      check(dec_tag(3'(c)), 8'(ctl_v), 8'(exp_ctl(3'(c))));
      check("R12 one select", 8'(bsr_sel_o ^ byp_sel_o), 8'h1);
    end
  endtask

  task automatic t_hold();
    load_ir(3'b000);
    capture_i = 1'b1;
    tick();
    capture_i = 1'b0;
    check("R5 ir held at capture", 8'(ir_o), 8'h0);
    shift_i = 1'b1;
    tdi_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 sysrst held in shift", 8'(sys_rst_req_o), 8'h1);
    end
    shift_i = 1'b0;
    tdi_i = 1'b0;
    tick();
    check("R5 ir held idle", 8'(ir_o), 8'h0);
    update_i = 1'b1;
    tick();
    update_i = 1'b0;
    check("R6 shifted ones loaded", 8'(ir_o), 8'h7);
  endtask

  task automatic t_tlr();
    load_ir(3'b001);
    check("R8 preload set", 8'(ir_o), 8'h1);
    tlr_i = 1'b1;
    tick();
    tlr_i = 1'b0;
    check("R2 tlr forces ones", 8'(ir_o), 8'h7);
    update_i = 1'b1;
    tick();
    update_i = 1'b0;
    check("R2 shift stage forced to ones", 8'(ir_o), 8'h7);
  endtask

  task automatic t_async_reset();
    load_ir(3'b101);
    check("R11 clamp set", 8'(ctl_v), 8'(6'b011010));
    #2;
    rst_ni = 1'b0;
    #1;
    check("R1 async reset ir", 8'(ir_o), 8'h7);
    check("R1 async reset ctl", 8'(ctl_v), 8'(6'b010000));
    @(negedge tck_i);
    rst_ni = 1'b1;
    tick();
    update_i = 1'b1;
    tick();
    update_i = 1'b0;
    check("R1 shift stage reset to ones", 8'(ir_o), 8'h7);
  endtask

  initial begin
    t_reset();
    t_capture_shift();
    t_decode_all();
    t_hold();
    t_tlr();
    t_async_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule